// File: doc/BRIEF.md
# LPC Error Capture and SMI Status

This block gathers fault and interrupt events reported by an LPC host interface and turns them into a small set of sticky status bits, two source enables and a level SMI request. Two sources can raise SMI: a serial-IRQ SMI request and an LPC bus error. Each has its own second-level status bit and enable. A single top-level SMI status bit summarises both sources, so a handler can poll one bit first and then look at the detailed one.

When an LPC error arrives and no earlier error is pending, the block records the address of the failing cycle and the kind of cycle (timeout, write, DMA, memory). That record stays frozen while the error status is set. Further errors only mark a separate "multiple errors" flag. Software uses a plain register port to read the status word, the error address and the top-level bit, to write the two enables and to clear any status bit by writing 1 to it.

Top module: `lpc_err_smi_top`

## Requirements
- R1: After a synchronous reset the status word, both enables, the top-level bit, the error address, `reg_rdata_o` and `smi_req_o` are all zero.
- R2: A pulse on `evt_serirq_i` sets status bit 0 (serial-IRQ SMI source) of register 0, whatever the enable. Enable bit 9 of register 0 is read/write.
- R3: A pulse on `evt_err_i` sets status bit 1 (LPC error SMI source) of register 0, whatever the enable. Enable bit 8 of register 0 is read/write.
- R4: Status bits 0 to 6 of register 0, and bit 0 of register 2 (top-level), are sticky. A write of 1 to such a bit clears it and a write of 0 leaves it unchanged.
- R5: The top-level bit is set in the cycle after `evt_serirq_i` arrives while enable bit 9 is 1, or after `evt_err_i` arrives while enable bit 8 is 1.
- R6: Clearing bit 0 by writing 1 also clears the top-level bit, but only if bit 1 is 0 after that write. Clearing bit 1 does the same only if bit 0 is 0 after that write.
- R7: Status bit 2 (multiple errors) is set when `evt_err_i` arrives while bit 1 is already set.
- R8: Bits 3 (timeout), 4 (write), 5 (DMA) and 6 (memory) take the values of `evt_timeout_i`, `evt_write_i`, `evt_dma_i` and `evt_mem_i` only for an error that arrives while bit 1 is clear. Later errors do not change them.
- R9: Register 1 (read-only) holds `evt_addr_i` from the first error, frozen while bit 1 is set. Writes to register 1 are ignored.
- R10: `smi_req_o` is registered and equals (bit 0 AND bit 9) OR (bit 1 AND bit 8), changing in the same cycle as those bits.
- R11: If an event and a write-1 clear hit the same status bit in one cycle, the event wins and the bit stays set.
- R12: `reg_rdata_o` is registered: one cycle after `reg_addr_i` is presented it shows that register's contents from before that edge. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_serirq_i | input | 1 | Serial-IRQ SMI request pulse |
| evt_err_i | input | 1 | LPC error pulse |
| evt_timeout_i | input | 1 | Error was a timeout (qualifies evt_err_i) |
| evt_write_i | input | 1 | Failing cycle was a write |
| evt_dma_i | input | 1 | Failing cycle was DMA |
| evt_mem_i | input | 1 | Failing cycle was a memory cycle |
| evt_addr_i | input | ADDR_W | Address of the failing cycle |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Register select: 0 status/enable, 1 error address, 2 top-level |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Registered read data |
| smi_req_o | output | 1 | Level SMI request |

## Verification
A single serial-IRQ event is applied with the enable off and then on. This separates recording the status from raising SMI and from setting the top-level bit. A first error followed by a second one with a different cycle type and address shows whether capture freezes and whether only the multiple-errors flag moves. Clears of one source are tried while the other source is pending and while it is idle, which tells the conditional top-level clear apart from an unconditional one. Clears issued in the same cycle as an event show the set-over-clear priority.

// File: rtl/lpc_err_pkg.sv
package lpc_err_pkg;

  // status word bit positions
  localparam int unsigned BIT_SER    = 0;
  localparam int unsigned BIT_ERR    = 1;
  localparam int unsigned BIT_MULT   = 2;
  localparam int unsigned BIT_CLS0   = 3;  // first of the class bits
  localparam int unsigned BIT_EN_ERR = 8;
  localparam int unsigned BIT_EN_SER = 9;

  // class bits: timeout, write, dma, memory (ascending positions)
  localparam int unsigned NUM_CLS = 4;

  // register selects
  localparam int unsigned SEL_STAT = 0;
  localparam int unsigned SEL_ADDR = 1;
  localparam int unsigned SEL_TOP  = 2;

  typedef struct packed {
    logic clr_ser;
    logic clr_err;
    logic clr_mult;
    logic clr_top;
    logic en_we;
    logic en_ser_wd;
    logic en_err_wd;
  } ctl_t;

endpackage

// File: rtl/lpc_reg_port.sv
module lpc_reg_port
  import lpc_err_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned REG_AW = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr_i,
  input  logic [REG_AW-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  input  logic               ser_q,
  input  logic               err_q,
  input  logic               mult_q,
  input  logic [NUM_CLS-1:0] cls_q,
  input  logic               en_ser_q,
  input  logic               en_err_q,
  input  logic               top_q,
  input  logic [ADDR_W-1:0]  err_addr_q,
  output ctl_t               ctl_o,
  output logic [NUM_CLS-1:0] clr_cls_o,
  output logic [DATA_W-1:0]  reg_rdata_o
);

  localparam logic [REG_AW-1:0] A_STAT = REG_AW'(SEL_STAT);
  localparam logic [REG_AW-1:0] A_ADDR = REG_AW'(SEL_ADDR);
  localparam logic [REG_AW-1:0] A_TOP  = REG_AW'(SEL_TOP);

  logic wr_stat;
  logic wr_top;
  logic [DATA_W-1:0] stat_word;
  logic [DATA_W-1:0] rd_mux;

  assign wr_stat = reg_wr_i && (reg_addr_i == A_STAT);
  assign wr_top  = reg_wr_i && (reg_addr_i == A_TOP);

  always_comb begin
    ctl_o           = '0;
    ctl_o.clr_ser   = wr_stat && reg_wdata_i[BIT_SER];
    ctl_o.clr_err   = wr_stat && reg_wdata_i[BIT_ERR];
    ctl_o.clr_mult  = wr_stat && reg_wdata_i[BIT_MULT];
    ctl_o.clr_top   = wr_top  && reg_wdata_i[0];
    ctl_o.en_we     = wr_stat;
    ctl_o.en_ser_wd = reg_wdata_i[BIT_EN_SER];
    ctl_o.en_err_wd = reg_wdata_i[BIT_EN_ERR];
  end

  for (genvar k = 0; k < NUM_CLS; k++) begin : g_clr
    assign clr_cls_o[k] = wr_stat && reg_wdata_i[BIT_CLS0+k];
  end

  always_comb begin
    stat_word                        = '0;
    stat_word[BIT_SER]               = ser_q;
    stat_word[BIT_ERR]               = err_q;
    stat_word[BIT_MULT]              = mult_q;
    stat_word[BIT_CLS0 +: NUM_CLS]   = cls_q;
    stat_word[BIT_EN_ERR]            = en_err_q;
    stat_word[BIT_EN_SER]            = en_ser_q;
  end

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr_i)
      A_STAT:  rd_mux = stat_word;
      A_ADDR:  rd_mux = DATA_W'(err_addr_q);
      A_TOP:   rd_mux[0] = top_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata_o <= '0;
    else     reg_rdata_o <= rd_mux;
  end

endmodule

// File: rtl/lpc_err_capture.sv
module lpc_err_capture
  import lpc_err_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               evt_err_i,
  input  logic [NUM_CLS-1:0] evt_cls_i,
  input  logic [ADDR_W-1:0]  evt_addr_i,
  input  logic               clr_err_i,
  input  logic               clr_mult_i,
  input  logic [NUM_CLS-1:0] clr_cls_i,
  output logic               err_q,
  output logic               err_n,
  output logic               mult_q,
  output logic [NUM_CLS-1:0] cls_q,
  output logic [ADDR_W-1:0]  addr_q
);

  logic first_err;
  logic mult_n;

  // a new record is only taken when nothing is pending
  assign first_err = evt_err_i && !err_q;
  assign err_n     = evt_err_i || (err_q && !clr_err_i);
  assign mult_n    = (evt_err_i && err_q) || (mult_q && !clr_mult_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q  <= 1'b0;
      mult_q <= 1'b0;
    end else begin
      err_q  <= err_n;
      mult_q <= mult_n;
    end
  end

  for (genvar k = 0; k < NUM_CLS; k++) begin : g_cls
    logic cls_n;
    assign cls_n = (first_err && evt_cls_i[k]) || (cls_q[k] && !clr_cls_i[k]);
    always_ff @(posedge clk) begin
      if (rst) cls_q[k] <= 1'b0;
      else     cls_q[k] <= cls_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            addr_q <= '0;
    else if (first_err) addr_q <= evt_addr_i;
  end

endmodule

// File: rtl/lpc_smi_ctrl.sv
module lpc_smi_ctrl
  import lpc_err_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic evt_serirq_i,
  input  logic evt_err_i,
  input  logic err_n_i,
  input  ctl_t ctl_i,
  output logic ser_q,
  output logic en_ser_q,
  output logic en_err_q,
  output logic top_q,
  output logic smi_req_o
);

  logic ser_n;
  logic en_ser_n;
  logic en_err_n;
  logic top_set;
  logic top_clr;
  logic top_n;

  assign ser_n    = evt_serirq_i || (ser_q && !ctl_i.clr_ser);
  assign en_ser_n = ctl_i.en_we ? ctl_i.en_ser_wd : en_ser_q;
  assign en_err_n = ctl_i.en_we ? ctl_i.en_err_wd : en_err_q;

  assign top_set = (evt_serirq_i && en_ser_q) || (evt_err_i && en_err_q);
  // a source clear drops the summary only when the other source is idle
  assign top_clr = ctl_i.clr_top
                || (ctl_i.clr_ser && !err_n_i)
                || (ctl_i.clr_err && !ser_n);
  assign top_n   = top_set || (top_q && !top_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_q     <= 1'b0;
      en_ser_q  <= 1'b0;
      en_err_q  <= 1'b0;
      top_q     <= 1'b0;
      smi_req_o <= 1'b0;
    end else begin
      ser_q     <= ser_n;
      en_ser_q  <= en_ser_n;
      en_err_q  <= en_err_n;
      top_q     <= top_n;
      smi_req_o <= (ser_n && en_ser_n) || (err_n_i && en_err_n);
    end
  end

endmodule

// File: rtl/lpc_err_smi_top.sv
module lpc_err_smi_top
  import lpc_err_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_AW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_serirq_i,
  input  logic              evt_err_i,
  input  logic              evt_timeout_i,
  input  logic              evt_write_i,
  input  logic              evt_dma_i,
  input  logic              evt_mem_i,
  input  logic [ADDR_W-1:0] evt_addr_i,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              smi_req_o
);

  ctl_t               ctl;
  logic [NUM_CLS-1:0] clr_cls;
  logic [NUM_CLS-1:0] evt_cls;
  logic               ser_q;
  logic               err_q;
  logic               err_n;
  logic               mult_q;
  logic [NUM_CLS-1:0] cls_q;
  logic               en_ser_q;
  logic               en_err_q;
  logic               top_q;
  logic [ADDR_W-1:0]  err_addr_q;

  assign evt_cls = {evt_mem_i, evt_dma_i, evt_write_i, evt_timeout_i};

  lpc_reg_port #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_AW(REG_AW)
  ) u_port (
    .clk(clk), .rst(rst),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .ser_q(ser_q), .err_q(err_q), .mult_q(mult_q), .cls_q(cls_q),
    .en_ser_q(en_ser_q), .en_err_q(en_err_q), .top_q(top_q),
    .err_addr_q(err_addr_q),
    .ctl_o(ctl), .clr_cls_o(clr_cls), .reg_rdata_o(reg_rdata_o)
  );

  lpc_err_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst(rst),
    .evt_err_i(evt_err_i), .evt_cls_i(evt_cls), .evt_addr_i(evt_addr_i),
    .clr_err_i(ctl.clr_err), .clr_mult_i(ctl.clr_mult), .clr_cls_i(clr_cls),
    .err_q(err_q), .err_n(err_n), .mult_q(mult_q), .cls_q(cls_q),
    .addr_q(err_addr_q)
  );

  lpc_smi_ctrl u_smi (
    .clk(clk), .rst(rst),
    .evt_serirq_i(evt_serirq_i), .evt_err_i(evt_err_i), .err_n_i(err_n),
    .ctl_i(ctl),
    .ser_q(ser_q), .en_ser_q(en_ser_q), .en_err_q(en_err_q),
    .top_q(top_q), .smi_req_o(smi_req_o)
  );

endmodule

// File: rtl/lpc_err_smi_chk.sv
module lpc_err_smi_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_AW = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              evt_serirq_i,
  input logic              evt_err_i,
  input logic              reg_wr_i,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              smi_req_o,
  input logic              ser_q,
  input logic              err_q,
  input logic              mult_q,
  input logic              en_ser_q,
  input logic              en_err_q,
  input logic              top_q,
  input logic [ADDR_W-1:0] err_addr_q
);

  logic wr_stat;
  assign wr_stat = reg_wr_i && (reg_addr_i == REG_AW'(0));

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!ser_q && !err_q && !mult_q && !top_q && !smi_req_o && err_addr_q == '0));

  assert_w1c_ser_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_stat && reg_wdata_i[0] && !evt_serirq_i) |=> !ser_q);

  assert_sticky_ser_R4: assert property (@(posedge clk) disable iff (rst)
    (ser_q && !(wr_stat && reg_wdata_i[0])) |=> ser_q);

  assert_top_set_R5: assert property (@(posedge clk) disable iff (rst)
    ((evt_serirq_i && en_ser_q) || (evt_err_i && en_err_q)) |=> top_q);

  assert_cond_keep_R6: assert property (@(posedge clk) disable iff (rst)
    (top_q && err_q && wr_stat && reg_wdata_i[0] && !reg_wdata_i[1]) |=> top_q);

  assert_multi_R7: assert property (@(posedge clk) disable iff (rst)
    (evt_err_i && err_q) |=> mult_q);

  assert_addr_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    err_q |=> $stable(err_addr_q));

  assert_smi_level_R10: assert property (@(posedge clk) disable iff (rst)
    smi_req_o == ((ser_q && en_ser_q) || (err_q && en_err_q)));

  assert_event_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (evt_serirq_i || evt_err_i) |=> ((ser_q || !$past(evt_serirq_i)) && (err_q || !$past(evt_err_i))));

endmodule

bind lpc_err_smi_top lpc_err_smi_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW)
) u_chk (
  .clk(clk), .rst(rst),
  .evt_serirq_i(evt_serirq_i), .evt_err_i(evt_err_i),
  .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .smi_req_o(smi_req_o),
  .ser_q(ser_q), .err_q(err_q), .mult_q(mult_q),
  .en_ser_q(en_ser_q), .en_err_q(en_err_q), .top_q(top_q),
  .err_addr_q(err_addr_q)
);

// File: tb/tb_lpc_err_smi_top.sv
`timescale 1ns/1ps
module tb_lpc_err_smi_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        evt_serirq_i = 1'b0, evt_err_i = 1'b0, evt_timeout_i = 1'b0;
  logic        evt_write_i = 1'b0, evt_dma_i = 1'b0, evt_mem_i = 1'b0;
  logic [31:0] evt_addr_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        smi_req_o;

  always #2.5 clk = ~clk;

  lpc_err_smi_top dut (
    .clk(clk), .rst(rst),
    .evt_serirq_i(evt_serirq_i), .evt_err_i(evt_err_i),
    .evt_timeout_i(evt_timeout_i), .evt_write_i(evt_write_i),
    .evt_dma_i(evt_dma_i), .evt_mem_i(evt_mem_i), .evt_addr_i(evt_addr_i),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .smi_req_o(smi_req_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  bit m_ser, m_err, m_mult, m_to, m_wr, m_dma, m_mem, m_ens, m_ene, m_top, m_smi;
  bit [31:0] m_addr, m_rd;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    bit ws, wt, cs, ce, first;
    bit ns, ne;
    if (rst) begin
      {m_ser, m_err, m_mult, m_to, m_wr, m_dma, m_mem, m_ens, m_ene, m_top, m_smi} = '0;
      m_addr = '0; m_rd = '0;
      return;
    end
    case (reg_addr_i)
      2'd0: m_rd = {22'b0, m_ens, m_ene, 1'b0, m_mem, m_dma, m_wr, m_to, m_mult, m_err, m_ser};
      2'd1: m_rd = m_addr;
      2'd2: m_rd = {31'b0, m_top};
      default: m_rd = '0;
    endcase
    ws = reg_wr_i && reg_addr_i == 2'd0;
    wt = reg_wr_i && reg_addr_i == 2'd2;
    cs = ws && reg_wdata_i[0];
    ce = ws && reg_wdata_i[1];
    first = evt_err_i && !m_err;
    ns = evt_serirq_i || (m_ser && !cs);
    ne = evt_err_i || (m_err && !ce);
    m_top = (evt_serirq_i && m_ens) || (evt_err_i && m_ene) ||
            (m_top && !((cs && !ne) || (ce && !ns) || (wt && reg_wdata_i[0])));
    m_mult = (evt_err_i && m_err) || (m_mult && !(ws && reg_wdata_i[2]));
    m_to  = (first && evt_timeout_i) || (m_to  && !(ws && reg_wdata_i[3]));
    m_wr  = (first && evt_write_i)   || (m_wr  && !(ws && reg_wdata_i[4]));
    m_dma = (first && evt_dma_i)     || (m_dma && !(ws && reg_wdata_i[5]));
    m_mem = (first && evt_mem_i)     || (m_mem && !(ws && reg_wdata_i[6]));
    if (first) m_addr = evt_addr_i;
    m_ser = ns; m_err = ne;
    if (ws) begin m_ens = reg_wdata_i[9]; m_ene = reg_wdata_i[8]; end
    m_smi = (m_ser && m_ens) || (m_err && m_ene);
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag, "rdata", reg_rdata_o, m_rd);
    check(tag, "smi_req", {31'b0, smi_req_o}, {31'b0, m_smi});
    {evt_serirq_i, evt_err_i, evt_timeout_i, evt_write_i, evt_dma_i, evt_mem_i} = '0;
    reg_wr_i = 1'b0;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
  endtask

  task automatic rd(logic [1:0] a);
    reg_addr_i = a;
  endtask

  initial begin
    @(negedge clk);
    tick("R1"); tick("R1");
    rst = 1'b0;
    rd(0); tick("R1"); rd(1); tick("R1"); rd(2); tick("R1");
    // serial-IRQ with enable off
    rd(0); evt_serirq_i = 1; tick("R2"); tick("R2");
    rd(2); tick("R5");
    // enable serial source, write 0 to status bits
    wr(0, 32'h200); tick("R10"); rd(0); tick("R4");
    // event with enable: top-level set
    evt_serirq_i = 1; tick("R5"); rd(2); tick("R5");
    // clear serial source, error side idle -> top cleared
    wr(0, 32'h201); tick("R6"); rd(2); tick("R6"); rd(0); tick("R6");
    // enable error source, first error (write, address A)
    wr(0, 32'h300); tick("R3");
    evt_err_i = 1; evt_write_i = 1; evt_addr_i = 32'hA000_1234; tick("R3");
    rd(0); tick("R8"); rd(1); tick("R9"); rd(2); tick("R5");
    // second error (DMA, address B)
    evt_err_i = 1; evt_dma_i = 1; evt_addr_i = 32'hB000_5678; tick("R7");
    rd(0); tick("R7"); rd(1); tick("R9");
    // write to error address register ignored
    wr(1, 32'hFFFF_FFFF); tick("R9"); rd(1); tick("R9");
    // serial pending, clear error: top kept
    evt_serirq_i = 1; rd(0); tick("R6");
    wr(0, 32'h302); tick("R6"); rd(2); tick("R6");
    // direct top clear
    wr(2, 32'h1); tick("R4"); rd(2); tick("R4");
    // clear serial together with a new serial event: event wins
    wr(0, 32'h301); evt_serirq_i = 1; tick("R11"); rd(0); tick("R11"); rd(2); tick("R11");
    // clear error together with a new error event
    wr(0, 32'h302); evt_err_i = 1; evt_mem_i = 1; evt_addr_i = 32'hC0; tick("R11");
    rd(0); tick("R11"); rd(1); tick("R11");
    // clear everything, then fresh error with timeout + memory
    wr(0, 32'h37F); tick("R4"); rd(0); tick("R4");
    evt_err_i = 1; evt_timeout_i = 1; evt_mem_i = 1; evt_addr_i = 32'hD00D_0001; tick("R8");
    rd(0); tick("R8"); rd(1); tick("R9");
    // disable sources: smi drops while status stays
    wr(0, 32'h000); tick("R10"); rd(0); tick("R10");
    rd(3); tick("R12"); tick("R12");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule